// File: doc/BRIEF.md
# I2C Target with Programmable Wait

This block is an I2C target engine. It runs on a system clock that oversamples the SCL and SDA lines. It finds start and stop conditions on the bus and shifts in the 7-bit address and the direction bit. After a matching address it receives or sends data bytes. At defined SCL falling edges it raises a one-cycle interrupt and holds SCL low (a wait) until the host releases it. SCL and SDA are open-drain lines, so the block drives them only through pull-down enables.

The host side uses plain signals. It supplies the own address, a wait-timing select, an acknowledge enable, and four single-cycle strobes: wait release, shift-register write, start request and stop request. Any one of the four strobes ends a wait. For data bytes the timing select picks whether the interrupt and wait fall after the 8th or the 9th clock. A cleared select gives the host the chance to choose the ACK level before the 9th clock. A set select gives it the whole byte, acknowledge included, in one stop.

Top module: `i2c_tgt_wait`

## Requirements
- R1: For a data byte with `wait_late`=0 (sampled at the 8th SCL fall), the block raises `irq` with cause 2 (data) and asserts `scl_oe` just after the 8th SCL fall of that byte, for received and transmitted bytes alike.
- R2: For a data byte with `wait_late`=1, there is no interrupt or wait at the 8th fall. `irq` with cause 2 and `scl_oe` follow the 9th SCL fall.
- R3: When bits 7:1 of the address byte equal `own_addr`, the block pulls SDA low during the 9th clock whatever `ack_en` holds. It raises `irq` with cause 1 (address) and asserts `scl_oe` after the 9th fall, whatever `wait_late` holds. `dir_tx` takes address bit 0 (1 = the target transmits).
- R4: When the address neither matches nor is an extension code, the block drives neither line and raises no interrupt until the next start condition.
- R5: An address byte whose top four bits are 0000 or whose top five bits are 11110 is an extension code. It raises `irq` with cause 1 and a wait after the 8th fall, and sets `ext_seen` until the next start. The ACK for it comes from `ack_en` at release.
- R6: While `scl_oe` is asserted, a single-cycle pulse on `wait_rel`, `shr_we`, `start_rq` or `stop_rq` clears `scl_oe` at the next clock edge.
- R7: On received data bytes the ACK level is taken from `ack_en` (1 = pull SDA low) at wait release when `wait_late`=0, and at the 8th fall when `wait_late`=1.
- R8: A stop condition (SDA rising while SCL is high) raises `irq` with cause 3 (stop) and ends any transfer.
- R9: In transmit, the byte written through `shr_we` goes out MSB first, one bit after each SCL fall. A master NACK on the 9th clock ends the transmission, and SDA stays released.
- R10: `irq` is high for exactly one clock per event, and `irq_cause` is valid while it is high.
- R11: After reset, `scl_oe`, `sda_oe`, `irq` and `ext_seen` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_oe | output | 1 | SCL pull-down enable (wait) |
| sda_oe | output | 1 | SDA pull-down enable |
| own_addr | input | 7 | Own 7-bit target address |
| wait_late | input | 1 | 0: data wait at 8th fall, 1: at 9th fall |
| ack_en | input | 1 | Acknowledge received data bytes |
| wait_rel | input | 1 | Wait release strobe |
| shr_we | input | 1 | Shift-register write strobe (also releases) |
| shr_wdata | input | 8 | Shift-register write data |
| start_rq | input | 1 | Start request strobe (releases wait) |
| stop_rq | input | 1 | Stop request strobe (releases wait) |
| shr_rdata | output | 8 | Shift-register contents |
| irq | output | 1 | One-clock interrupt pulse |
| irq_cause | output | 2 | 1 address, 2 data, 3 stop |
| ext_seen | output | 1 | Extension code received since start |
| dir_tx | output | 1 | Address direction bit |

## Verification
The bench aims at the moments where the 8th-fall and 9th-fall rules meet. It checks that the address byte ignores `wait_late`, so a design applying the data rule there would stretch one clock too early. It also checks that the ACK level comes from `ack_en` at release and not from its value at the 8th fall, which a design latching too early would turn into a wrong NACK. A non-matching address followed by a data byte must leave the bus untouched, and a single stray stretch cycle is reported. On the transmit side, a master NACK must leave SDA free so that the stop can form, and both extension-code patterns must raise the early interrupt.

// File: rtl/iw_pkg.sv
package iw_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = BYTE_W - 1;
    localparam int CNT_W  = $clog2(BYTE_W + 2);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_HOLD
    } iw_state_e;

    typedef enum logic [1:0] {
        CZ_NONE = 2'd0,
        CZ_ADDR = 2'd1,
        CZ_DATA = 2'd2,
        CZ_STOP = 2'd3
    } iw_cause_e;
endpackage

// File: rtl/iw_bus_events.sv
module iw_bus_events #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic ev_start,
    output logic ev_stop
);
    logic [1:0] raw;
    logic [1:0] cur;
    logic [1:0] prv;

    assign raw = {sda_in, scl_in};

    for (genvar i = 0; i < 2; i++) begin : g_line
        logic [STAGES:0] sr;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr <= '1;
            else        sr <= {sr[STAGES-1:0], raw[i]};
        end
        assign cur[i] = sr[STAGES-1];
        assign prv[i] = sr[STAGES];
    end

    assign sda_lvl  = cur[1];
    assign scl_rise = cur[0] & ~prv[0];
    assign scl_fall = ~cur[0] & prv[0];
    assign ev_start = cur[0] & prv[0] & prv[1] & ~cur[1];
    assign ev_stop  = cur[0] & prv[0] & ~prv[1] & cur[1];
endmodule

// File: rtl/iw_shifter.sv
module iw_shifter
    import iw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              rise,
    input  logic              fall,
    input  logic              sda,
    input  logic              load,
    input  logic [BYTE_W-1:0] ldata,
    output logic [BYTE_W-1:0] sh,
    output logic [CNT_W-1:0]  rcnt
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W + 1);
    localparam logic [CNT_W-1:0] DATA = CNT_W'(BYTE_W);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    rcnt <= '0;
        else if (clr)                  rcnt <= '0;
        else if (fall && rcnt == LAST) rcnt <= '0;
        else if (rise && rcnt != LAST) rcnt <= rcnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    sh <= '0;
        else if (load)                 sh <= ldata;
        else if (rise && rcnt < DATA)  sh <= {sh[BYTE_W-2:0], sda};
    end
endmodule

// File: rtl/i2c_tgt_wait.sv
module i2c_tgt_wait
    import iw_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       scl_oe,
    output logic       sda_oe,
    input  logic [6:0] own_addr,
    input  logic       wait_late,
    input  logic       ack_en,
    input  logic       wait_rel,
    input  logic       shr_we,
    input  logic [7:0] shr_wdata,
    input  logic       start_rq,
    input  logic       stop_rq,
    output logic [7:0] shr_rdata,
    output logic       irq,
    output logic [1:0] irq_cause,
    output logic       ext_seen,
    output logic       dir_tx
);
    localparam logic [CNT_W-1:0] C8 = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] C9 = CNT_W'(BYTE_W + 1);

    logic              sda_lvl, scl_rise, scl_fall, ev_start, ev_stop;
    logic [BYTE_W-1:0] sh;
    logic [CNT_W-1:0]  rcnt;
    logic              relev, is_ext, addr_hit, rel_bit;

    iw_state_e st, st_n, resume_q, resume_n;
    iw_cause_e cause_q, cause_n;
    logic sda_n, irq_n;
    logic ackrel_q, ackrel_n, drvrel_q, drvrel_n;
    logic late_q, late_n, nack_q, nack_n, ext_q, ext_n, dir_q, dir_n;

    iw_bus_events #(.STAGES(SYNC_STAGES)) u_ev (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .ev_start (ev_start),
        .ev_stop  (ev_stop)
    );

    iw_shifter u_sh (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ev_start),
        .rise  (scl_rise),
        .fall  (scl_fall),
        .sda   (sda_lvl),
        .load  (shr_we),
        .ldata (shr_wdata),
        .sh    (sh),
        .rcnt  (rcnt)
    );

    assign relev    = wait_rel | shr_we | start_rq | stop_rq;
    assign is_ext   = (sh[7:4] == 4'b0000) || (sh[7:3] == 5'b11110);
    assign addr_hit = (sh[7:1] == own_addr);
    assign rel_bit  = shr_we ? shr_wdata[7] : sh[7];

    // next-state and next-output decision
    always_comb begin
        st_n     = st;
        resume_n = resume_q;
        cause_n  = cause_q;
        sda_n    = sda_oe;
        irq_n    = 1'b0;
        ackrel_n = ackrel_q;
        drvrel_n = drvrel_q;
        late_n   = late_q;
        nack_n   = nack_q;
        ext_n    = ext_q;
        dir_n    = dir_q;
        if (ev_stop) begin
            st_n    = ST_IDLE;
            sda_n   = 1'b0;
            irq_n   = 1'b1;
            cause_n = CZ_STOP;
        end else if (ev_start) begin
            st_n  = ST_ADDR;
            sda_n = 1'b0;
            ext_n = 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                end
                ST_ADDR: begin
                    if (scl_fall && rcnt == C8) begin
                        if (is_ext) begin
                            ext_n    = 1'b1;
                            dir_n    = 1'b0;
                            irq_n    = 1'b1;
                            cause_n  = CZ_ADDR;
                            st_n     = ST_HOLD;
                            resume_n = ST_RX_ACK;
                            ackrel_n = 1'b1;
                            drvrel_n = 1'b0;
                            late_n   = 1'b0;
                        end else if (addr_hit) begin
                            sda_n = 1'b1;
                            dir_n = sh[0];
                            st_n  = ST_ADDR_ACK;
                        end else begin
                            st_n = ST_IDLE;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall && rcnt == C9) begin
                        sda_n    = 1'b0;
                        irq_n    = 1'b1;
                        cause_n  = CZ_ADDR;
                        st_n     = ST_HOLD;
                        resume_n = dir_q ? ST_TX : ST_RX;
                        ackrel_n = 1'b0;
                        drvrel_n = dir_q;
                    end
                end
                ST_RX: begin
                    if (scl_fall && rcnt == C8) begin
                        late_n = wait_late;
                        if (!wait_late) begin
                            irq_n    = 1'b1;
                            cause_n  = CZ_DATA;
                            st_n     = ST_HOLD;
                            resume_n = ST_RX_ACK;
                            ackrel_n = 1'b1;
                            drvrel_n = 1'b0;
                        end else begin
                            sda_n = ack_en;
                            st_n  = ST_RX_ACK;
                        end
                    end
                end
                ST_RX_ACK: begin
                    if (scl_fall && rcnt == C9) begin
                        sda_n = 1'b0;
                        if (late_q) begin
                            irq_n    = 1'b1;
                            cause_n  = CZ_DATA;
                            st_n     = ST_HOLD;
                            resume_n = ST_RX;
                            ackrel_n = 1'b0;
                            drvrel_n = 1'b0;
                        end else begin
                            st_n = ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (rcnt == C8) begin
                            sda_n  = 1'b0;
                            late_n = wait_late;
                            if (!wait_late) begin
                                irq_n    = 1'b1;
                                cause_n  = CZ_DATA;
                                st_n     = ST_HOLD;
                                resume_n = ST_TX_ACK;
                                ackrel_n = 1'b0;
                                drvrel_n = 1'b0;
                            end else begin
                                st_n = ST_TX_ACK;
                            end
                        end else if (rcnt != '0) begin
                            sda_n = ~sh[7];
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        nack_n = sda_lvl;
                    end
                    if (scl_fall && rcnt == C9) begin
                        if (late_q) begin
                            irq_n    = 1'b1;
                            cause_n  = CZ_DATA;
                            st_n     = ST_HOLD;
                            resume_n = nack_q ? ST_IDLE : ST_TX;
                            ackrel_n = 1'b0;
                            drvrel_n = ~nack_q;
                        end else if (nack_q) begin
                            st_n = ST_IDLE;
                        end else begin
                            sda_n = ~sh[7];
                            st_n  = ST_TX;
                        end
                    end
                end
                ST_HOLD: begin
                    if (relev) begin
                        st_n = resume_q;
                        if (ackrel_q)      sda_n = ack_en;
                        else if (drvrel_q) sda_n = ~rel_bit;
                        else               sda_n = 1'b0;
                    end
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_n;
    end

    // output and context registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe   <= 1'b0;
            irq      <= 1'b0;
            cause_q  <= CZ_NONE;
            resume_q <= ST_IDLE;
            ackrel_q <= 1'b0;
            drvrel_q <= 1'b0;
            late_q   <= 1'b0;
            nack_q   <= 1'b0;
            ext_q    <= 1'b0;
            dir_q    <= 1'b0;
        end else begin
            sda_oe   <= sda_n;
            irq      <= irq_n;
            cause_q  <= cause_n;
            resume_q <= resume_n;
            ackrel_q <= ackrel_n;
            drvrel_q <= drvrel_n;
            late_q   <= late_n;
            nack_q   <= nack_n;
            ext_q    <= ext_n;
            dir_q    <= dir_n;
        end
    end

    assign scl_oe    = (st == ST_HOLD);
    assign irq_cause = cause_q;
    assign shr_rdata = sh;
    assign ext_seen  = ext_q;
    assign dir_tx    = dir_q;
endmodule

// File: rtl/iw_checker.sv
module iw_checker
    import iw_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input iw_state_e  st,
    input logic       ev_stop,
    input logic       relev,
    input logic       irq,
    input logic [1:0] irq_cause,
    input logic       scl_oe,
    input logic       sda_oe
);
    // R10: interrupt is a single-cycle pulse
    a_r10_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R6: any release strobe ends the wait on the next edge
    a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_oe && relev) |=> !scl_oe);

    // R1 / R2: a wait never starts without an interrupt in the same cycle
    a_r1_wait_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_oe) |-> irq);

    // R8: stop on the bus yields a stop-cause interrupt
    a_r8_stop_irq: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stop |=> (irq && irq_cause == 2'd3));

    // R3: acknowledge phase of a matching address always pulls SDA
    a_r3_addr_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ADDR_ACK) |-> sda_oe);

    // R4: while ignoring the bus neither line is driven
    a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> (!sda_oe && !scl_oe));
endmodule

bind i2c_tgt_wait iw_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .st        (st),
    .ev_stop   (ev_stop),
    .relev     (relev),
    .irq       (irq),
    .irq_cause (irq_cause),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe)
);

// File: tb/i2c_tgt_wait_tb.sv
module i2c_tgt_wait_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_oe, sda_oe, irq, ext_seen, dir_tx;
    logic [1:0] irq_cause;
    logic [7:0] shr_rdata;
    logic [6:0] own_addr = 7'h2A;
    logic wait_late = 1'b0, ack_en = 1'b0, wait_rel = 1'b0, shr_we = 1'b0;
    logic start_rq = 1'b0, stop_rq = 1'b0;
    logic [7:0] shr_wdata = 8'h00;
    logic m_scl_low = 1'b0, m_sda_low = 1'b0;
    logic scl_line, sda_line;

    int tests = 0, fails = 0;
    int irq_cnt = 0, dbl_irq = 0, stray = 0;
    logic [1:0] last_cause = 2'd0;
    logic prev_irq = 1'b0, hold_ok = 1'b0, done = 1'b0;

    assign scl_line = ~(m_scl_low | scl_oe);
    assign sda_line = ~(m_sda_low | sda_oe);

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_tgt_wait u_dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_line), .sda_in(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(own_addr),
        .wait_late(wait_late), .ack_en(ack_en), .wait_rel(wait_rel),
        .shr_we(shr_we), .shr_wdata(shr_wdata), .start_rq(start_rq),
        .stop_rq(stop_rq), .shr_rdata(shr_rdata), .irq(irq),
        .irq_cause(irq_cause), .ext_seen(ext_seen), .dir_tx(dir_tx)
    );

    // per-clock reference observations
    always @(negedge clk) begin
        if (rst_n) begin
            if (irq) begin
                irq_cnt++;
                last_cause = irq_cause;
                if (prev_irq) dbl_irq++;
            end
            prev_irq = irq;
            if (scl_oe && !hold_ok) stray++;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    task automatic do_bit(input logic b, output logic r, input bit e_irq,
                          input int e_cause, input bit e_hold, input string req);
        int n0;
        m_sda_low = ~b;
        tick(4);
        m_scl_low = 1'b0;
        while (!scl_line) @(negedge clk);
        tick(4);
        r = sda_line;
        n0 = irq_cnt;
        hold_ok = e_hold;
        m_scl_low = 1'b1;
        tick(6);
        chk((irq_cnt - n0) == int'(e_irq), req, "irq count at fall", irq_cnt - n0, int'(e_irq));
        if (e_irq) chk(int'(last_cause) == e_cause, req, "irq cause", last_cause, e_cause);
        chk(scl_oe == e_hold, req, "scl stretch at fall", scl_oe, e_hold);
    endtask

    task automatic release_wait(input int kind, input logic [7:0] wd);
        case (kind)
            0: wait_rel = 1'b1;
            1: begin shr_we = 1'b1; shr_wdata = wd; end
            2: start_rq = 1'b1;
            default: stop_rq = 1'b1;
        endcase
        tick(1);
        wait_rel = 1'b0; shr_we = 1'b0; start_rq = 1'b0; stop_rq = 1'b0;
        hold_ok = 1'b0;
        chk(scl_oe == 1'b0, "R6", "scl after release", scl_oe, 0);
    endtask

    task automatic wr_byte(input logic [7:0] v, input bit h8, input bit h9,
                           input int cz, input int rk8, input int rk9,
                           input logic [7:0] wd, input logic ae_rel,
                           output logic ack, input string req);
        logic r;
        for (int i = 7; i >= 1; i--) do_bit(v[i], r, 1'b0, 0, 1'b0, req);
        do_bit(v[0], r, h8, cz, h8, req);
        if (h8) begin
            ack_en = ae_rel;
            release_wait(rk8, wd);
        end
        do_bit(1'b1, ack, h9, cz, h9, req);
        if (h9) release_wait(rk9, wd);
    endtask

    task automatic rd_byte(output logic [7:0] got, input bit mack, input bit h8,
                           input bit h9, input int rk8, input int rk9,
                           input logic [7:0] wd, input string req);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            do_bit(1'b1, r, (i == 0) && h8, 2, (i == 0) && h8, req);
            got[i] = r;
        end
        if (h8) release_wait(rk8, wd);
        do_bit(~mack, r, h9, 2, h9, req);
        if (h9) release_wait(rk9, wd);
    endtask

    task automatic bus_start();
        m_sda_low = 1'b1;
        tick(6);
        m_scl_low = 1'b1;
        tick(6);
    endtask

    task automatic bus_stop();
        int n0;
        m_sda_low = 1'b1;
        tick(4);
        m_scl_low = 1'b0;
        while (!scl_line) @(negedge clk);
        tick(4);
        n0 = irq_cnt;
        m_sda_low = 1'b0;
        tick(8);
        chk((irq_cnt - n0) == 1, "R8", "stop irq count", irq_cnt - n0, 1);
        chk(last_cause == 2'd3, "R8", "stop cause", last_cause, 3);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            summary();
        end
    end

    initial begin
        logic a;
        logic [7:0] got;
        tick(5);
        rst_n = 1'b1;
        tick(3);
        // R11 reset state
        chk(scl_oe == 1'b0, "R11", "scl_oe", scl_oe, 0);
        chk(sda_oe == 1'b0, "R11", "sda_oe", sda_oe, 0);
        chk(irq == 1'b0 && irq_cnt == 0, "R11", "irq", irq_cnt, 0);
        chk(ext_seen == 1'b0, "R11", "ext_seen", ext_seen, 0);

        // write transfer: R3 address with ack_en=0, wait_late=1
        wait_late = 1'b1; ack_en = 1'b0;
        bus_start();
        wr_byte(8'h54, 1'b0, 1'b1, 1, 0, 0, 8'h00, 1'b0, a, "R3");
        chk(a == 1'b0, "R3", "address ACK forced", a, 0);
        chk(dir_tx == 1'b0, "R3", "direction", dir_tx, 0);
        chk(ext_seen == 1'b0, "R5", "no extension flag", ext_seen, 0);
        // R1 + R7: wait at 8th fall, ACK taken at release via start request
        wait_late = 1'b0; ack_en = 1'b0;
        wr_byte(8'hA5, 1'b1, 1'b0, 2, 2, 0, 8'h00, 1'b1, a, "R1");
        chk(a == 1'b0, "R7", "ACK from ack_en at release", a, 0);
        chk(shr_rdata == 8'hA5, "R1", "received byte", shr_rdata, 8'hA5);
        // R2 + R7: wait at 9th fall, ack_en=0 at 8th fall gives NACK
        wait_late = 1'b1; ack_en = 1'b0;
        wr_byte(8'h3C, 1'b0, 1'b1, 2, 0, 3, 8'h00, 1'b0, a, "R2");
        chk(a == 1'b1, "R7", "NACK with ack_en clear", a, 1);
        chk(shr_rdata == 8'h3C, "R2", "received byte", shr_rdata, 8'h3C);
        bus_stop();

        // R4: other address, then a data byte, all ignored
        bus_start();
        wr_byte(8'h40, 1'b0, 1'b0, 0, 0, 0, 8'h00, 1'b0, a, "R4");
        chk(a == 1'b1, "R4", "no ACK on mismatch", a, 1);
        wr_byte(8'h00, 1'b0, 1'b0, 0, 0, 0, 8'h00, 1'b0, a, "R4");
        chk(a == 1'b1, "R4", "data byte ignored", a, 1);
        chk(sda_oe == 1'b0, "R4", "sda released", sda_oe, 0);
        bus_stop();

        // R9 read transfer; address ignores wait_late=0 (R3)
        wait_late = 1'b0;
        bus_start();
        wr_byte(8'h55, 1'b0, 1'b1, 1, 0, 1, 8'h3C, 1'b0, a, "R3");
        chk(a == 1'b0, "R3", "read address ACK", a, 0);
        chk(dir_tx == 1'b1, "R3", "direction", dir_tx, 1);
        rd_byte(got, 1'b1, 1'b1, 1'b0, 1, 0, 8'h81, "R1");
        chk(got == 8'h3C, "R9", "first sent byte", got, 8'h3C);
        wait_late = 1'b1;
        rd_byte(got, 1'b0, 1'b0, 1'b1, 0, 0, 8'h00, "R2");
        chk(got == 8'h81, "R9", "second sent byte", got, 8'h81);
        tick(4);
        chk(sda_oe == 1'b0, "R9", "SDA free after NACK", sda_oe, 0);
        bus_stop();

        // R5 extension codes, both patterns
        bus_start();
        wr_byte(8'h00, 1'b1, 1'b0, 1, 0, 0, 8'h00, 1'b1, a, "R5");
        chk(a == 1'b0, "R5", "ext ACK from ack_en", a, 0);
        chk(ext_seen == 1'b1, "R5", "ext flag 0000", ext_seen, 1);
        bus_stop();
        bus_start();
        chk(ext_seen == 1'b0, "R5", "ext flag cleared at start", ext_seen, 0);
        wr_byte(8'hF0, 1'b1, 1'b0, 1, 0, 0, 8'h00, 1'b0, a, "R5");
        chk(a == 1'b1, "R5", "ext NACK with ack_en clear", a, 1);
        chk(ext_seen == 1'b1, "R5", "ext flag 11110", ext_seen, 1);
        bus_stop();

        tick(10);
        chk(dbl_irq == 0, "R10", "irq wider than one clock", dbl_irq, 0);
        chk(stray == 0, "R4", "unexpected stretch cycles", stray, 0);
        done = 1'b1;
        summary();
    end
endmodule